// File: doc/BRIEF.md
# Hybrid Roulette-Tournament Selection Unit

This block chooses parents for the next generation of a hardware genetic algorithm. After a start pulse it first reads every fitness word of the population once and adds them up. It then repeats a three-step pick until it has produced one index for each member of the new population:

- two candidates are drawn, each by its own fitness-weighted roulette spin;
- a random byte is compared with a programmable threshold;
- the comparison decides whether the stronger or the weaker of the two candidates survives.

A low threshold therefore keeps more of the weaker individuals, which preserves diversity. A high threshold pushes the population hard towards the fittest members.

The fitness memory sits outside the block and returns data one cycle after each read request. Random words come from an external generator. The block consumes exactly one word in every cycle in which it raises its take strobe. Each chosen index appears on the output for one cycle with a valid strobe, and a done flag marks the end of the round.

Top module: `ga_parent_picker`

## Requirements
- R1: After reset, `pick_valid`, `done`, `busy`, `mem_rd_en` and `rnd_take` are all 0.
- R2: A start pulse while idle captures `pop_count` (N) and `thresh_k` (k). Before any random word is consumed, the block reads fitness addresses 0 to N-1 once each, in ascending order.
- R3: A roulette spin uses a 16-bit random word w and the fitness total T. It forms the target t = (w*T)>>16 and selects the lowest index whose inclusive running fitness sum is strictly greater than t. This means an individual with zero fitness is never selected while T > 0.
- R4: Random words are consumed one per cycle with `rnd_take` high, in this order for every pick: first spin, second spin, duel word. A round of N picks therefore consumes exactly 3N words.
- R5: The duel compares r, bits [7:0] of its random word, with k. If r < k the fitter candidate is emitted; otherwise the less fit candidate is emitted. With k = 0 the weaker candidate always wins.
- R6: When both candidates have equal fitness, the candidate from the first spin is emitted, whatever the outcome of the duel comparison.
- R7: When T = 0, each spin selects index (w*N)>>16 and reads no memory.
- R8: A round emits exactly N indices, each as a one-cycle `pick_valid` pulse. `done` rises in the same cycle as the last pulse and stays high until the next accepted start. `busy` is high from the accepted start until the round ends.
- R9: A start pulse, or any change of `pop_count` or `thresh_k`, during a busy round has no effect on that round.
- R10: A start with `pop_count` = 0 raises `done` without any read, random word or pick.
- R11: Every read address and every emitted index is below N.

Note on R3: the spin consumes the random word in full, so w is the whole 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a round when idle |
| pop_count | input | 5 | Population size N, from 0 to 16 |
| thresh_k | input | 8 | Duel threshold k |
| mem_rd_en | output | 1 | Fitness read request |
| mem_addr | output | 4 | Fitness read address |
| mem_fit | input | 8 | Fitness data, valid one cycle after the request |
| rnd_in | input | 16 | Random word from the external generator |
| rnd_take | output | 1 | The word on `rnd_in` is consumed in this cycle |
| pick_valid | output | 1 | `pick_idx` carries a chosen parent |
| pick_idx | output | 4 | Chosen parent index |
| busy | output | 1 | Round in progress |
| done | output | 1 | Round complete |

## Verification
The bench aims at the edges of the roulette scan:

- Zero-fitness members sit at the front and in the middle of the population. An off-by-one in the comparison of the running sum with the target would select them, or would pick the index after the correct one.
- Rounds use k = 0 and k = 255, and populations in which every member has the same fitness. A design with an inverted comparison, or with ties decided towards the second candidate, emits a different index sequence from the one the bench models.
- An all-zero population must follow the uniform fallback and not hang waiting for a sum that never exceeds the target.
- A start pulse in the middle of a round, and an empty population, expose designs that reload their settings while busy or that emit a spurious pick.

// File: rtl/ga_pick_pkg.sv
package ga_pick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TOTAL = 3'd1,
        ST_DRAW  = 3'd2,
        ST_SCAN  = 3'd3,
        ST_DUEL  = 3'd4
    } pick_state_e;

endpackage

// File: rtl/ga_pick_scale.sv
// Maps a random word onto [0, range) by multiply and shift.
module ga_pick_scale #(
    parameter int RND_W = 16,
    parameter int RNG_W = 12
) (
    input  logic [RND_W-1:0] rnd,
    input  logic [RNG_W-1:0] range,
    output logic [RNG_W-1:0] scaled
);
    localparam int PW = RND_W + RNG_W;

    logic [PW-1:0] prod;

    always_comb begin
        prod   = PW'(rnd) * PW'(range);
        scaled = prod[PW-1:RND_W];
    end
endmodule

// File: rtl/ga_pick_reader.sv
// Issues fitness reads and tracks which index the returning data belongs to.
module ga_pick_reader #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [CNT_W-1:0] issue_idx,
    output logic             mem_rd_en,
    output logic [IDX_W-1:0] mem_addr,
    output logic             ret_valid,
    output logic [IDX_W-1:0] ret_idx
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } ret_t;

    ret_t ret_d, ret_q;

    always_comb begin
        mem_rd_en = issue;
        mem_addr  = issue_idx[IDX_W-1:0];
        ret_d.vld = issue;
        ret_d.idx = issue_idx[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ret_q <= '0;
        else        ret_q <= ret_d;
    end

    assign ret_valid = ret_q.vld;
    assign ret_idx   = ret_q.idx;
endmodule

// File: rtl/ga_pick_duel.sv
// Biased tournament between two candidates; candidate a wins ties.
module ga_pick_duel #(
    parameter int IDX_W = 4,
    parameter int FIT_W = 8,
    parameter int K_W   = 8
) (
    input  logic [K_W-1:0]   r,
    input  logic [K_W-1:0]   k,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [FIT_W-1:0] fit_a,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [FIT_W-1:0] fit_b,
    output logic [IDX_W-1:0] win_idx
);
    logic want_fit;
    logic a_wins;

    always_comb begin
        want_fit = (r < k);
        if (want_fit) a_wins = (fit_a >= fit_b);
        else          a_wins = (fit_a <= fit_b);
        win_idx = a_wins ? idx_a : idx_b;
    end
endmodule

// File: rtl/ga_parent_picker.sv
module ga_parent_picker
    import ga_pick_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int FIT_W = 8,
    parameter int RND_W = 16,
    parameter int K_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [IDX_W:0]      pop_count,
    input  logic [K_W-1:0]      thresh_k,
    output logic                mem_rd_en,
    output logic [IDX_W-1:0]    mem_addr,
    input  logic [FIT_W-1:0]    mem_fit,
    input  logic [RND_W-1:0]    rnd_in,
    output logic                rnd_take,
    output logic                pick_valid,
    output logic [IDX_W-1:0]    pick_idx,
    output logic                busy,
    output logic                done
);
    localparam int CNT_W = IDX_W + 1;
    localparam int SUM_W = FIT_W + IDX_W;

    typedef struct packed {
        pick_state_e                 state;
        logic [CNT_W-1:0]            pop;
        logic [K_W-1:0]              k;
        logic [CNT_W-1:0]            issue_idx;
        logic [CNT_W-1:0]            emitted;
        logic [SUM_W-1:0]            total;
        logic [SUM_W-1:0]            run_sum;
        logic [SUM_W-1:0]            target;
        logic                        second;
        logic [1:0][IDX_W-1:0]       cand_idx;
        logic [1:0][FIT_W-1:0]       cand_fit;
        logic                        pick_valid;
        logic [IDX_W-1:0]            pick_idx;
        logic                        done;
    } regs_t;

    regs_t d, q;

    logic             issue;
    logic             take_c;
    logic             ret_valid;
    logic [IDX_W-1:0] ret_idx;
    logic [SUM_W-1:0] roul_tgt;
    logic [CNT_W-1:0] uni_idx;
    logic [IDX_W-1:0] win_idx;
    logic [SUM_W-1:0] sum_next;
    logic [CNT_W-1:0] pop_lim;

    ga_pick_reader #(.IDX_W(IDX_W), .CNT_W(CNT_W)) reader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .issue_idx (q.issue_idx),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .ret_valid (ret_valid),
        .ret_idx   (ret_idx)
    );

    ga_pick_scale #(.RND_W(RND_W), .RNG_W(SUM_W)) roul_scale_i (
        .rnd    (rnd_in),
        .range  (q.total),
        .scaled (roul_tgt)
    );

    ga_pick_scale #(.RND_W(RND_W), .RNG_W(CNT_W)) uni_scale_i (
        .rnd    (rnd_in),
        .range  (q.pop),
        .scaled (uni_idx)
    );

    ga_pick_duel #(.IDX_W(IDX_W), .FIT_W(FIT_W), .K_W(K_W)) duel_i (
        .r       (rnd_in[K_W-1:0]),
        .k       (q.k),
        .idx_a   (q.cand_idx[0]),
        .fit_a   (q.cand_fit[0]),
        .idx_b   (q.cand_idx[1]),
        .fit_b   (q.cand_fit[1]),
        .win_idx (win_idx)
    );

    always_comb begin
        d            = q;
        d.pick_valid = 1'b0;
        issue        = 1'b0;
        take_c       = 1'b0;
        sum_next     = q.run_sum + SUM_W'(mem_fit);

        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.pop       = pop_count;
                    d.k         = thresh_k;
                    d.emitted   = '0;
                    d.issue_idx = '0;
                    d.total     = '0;
                    d.second    = 1'b0;
                    d.done      = (pop_count == '0);
                    if (pop_count != '0) d.state = ST_TOTAL;
                end
            end

            ST_TOTAL: begin
                issue = (q.issue_idx < q.pop);
                if (issue) d.issue_idx = q.issue_idx + CNT_W'(1);
                if (ret_valid) begin
                    d.total = q.total + SUM_W'(mem_fit);
                    if (CNT_W'(ret_idx) == q.pop - CNT_W'(1)) d.state = ST_DRAW;
                end
            end

            ST_DRAW: begin
                take_c = 1'b1;
                if (q.total == '0) begin
                    d.cand_idx[q.second] = uni_idx[IDX_W-1:0];
                    d.cand_fit[q.second] = '0;
                    if (q.second) d.state  = ST_DUEL;
                    else          d.second = 1'b1;
                end else begin
                    d.target    = roul_tgt;
                    d.run_sum   = '0;
                    d.issue_idx = '0;
                    d.state     = ST_SCAN;
                end
            end

            ST_SCAN: begin
                issue = (q.issue_idx < q.pop);
                if (issue) d.issue_idx = q.issue_idx + CNT_W'(1);
                if (ret_valid) begin
                    d.run_sum = sum_next;
                    if (sum_next > q.target) begin
                        d.cand_idx[q.second] = ret_idx;
                        d.cand_fit[q.second] = mem_fit;
                        if (q.second) begin
                            d.state = ST_DUEL;
                        end else begin
                            d.second = 1'b1;
                            d.state  = ST_DRAW;
                        end
                    end
                end
            end

            ST_DUEL: begin
                take_c       = 1'b1;
                d.pick_valid = 1'b1;
                d.pick_idx   = win_idx;
                d.emitted    = q.emitted + CNT_W'(1);
                d.second     = 1'b0;
                if (q.emitted + CNT_W'(1) == q.pop) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.state = ST_DRAW;
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rnd_take   = take_c;
    assign pick_valid = q.pick_valid;
    assign pick_idx   = q.pick_idx;
    assign busy       = (q.state != ST_IDLE);
    assign done       = q.done;
    assign pop_lim    = q.pop;
endmodule

// File: rtl/ga_parent_picker_chk.sv
module ga_parent_picker_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mem_rd_en,
    input logic [IDX_W-1:0] mem_addr,
    input logic             rnd_take,
    input logic             pick_valid,
    input logic [IDX_W-1:0] pick_idx,
    input logic             busy,
    input logic             done,
    input logic [IDX_W:0]   pop_lim
);
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ({1'b0, mem_addr} < pop_lim)); // R11

    AST_PICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ({1'b0, pick_idx} < pop_lim)); // R11

    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (pick_valid || pop_lim == '0)); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |=> !pick_valid); // R8

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !rnd_take)); // R10

    AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_lim == '0) |-> !mem_rd_en); // R10
endmodule

bind ga_parent_picker ga_parent_picker_chk #(.IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .rnd_take   (rnd_take),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .busy       (busy),
    .done       (done),
    .pop_lim    (pop_lim)
);

// File: tb/ga_parent_picker_tb_top.sv
module ga_parent_picker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  pop_count = '0;
    logic [7:0]  thresh_k = '0;
    logic        mem_rd_en;
    logic [3:0]  mem_addr;
    logic [7:0]  mem_fit = '0;
    logic [15:0] rnd_in;
    logic        rnd_take;
    logic        pick_valid;
    logic [3:0]  pick_idx;
    logic        busy;
    logic        done;

    int n_total = 0;
    int n_bad   = 0;

    logic [7:0]  fit_mem [16];
    logic [15:0] rseq [1024];
    int rptr;
    int got  [64];
    int ngot;
    int rdlog [64];
    int nrd;
    bit seen_take;
    int expv [64];
    int exp_end;

    always #4 clk = ~clk;

    ga_parent_picker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pop_count(pop_count),
        .thresh_k(thresh_k), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_fit(mem_fit), .rnd_in(rnd_in), .rnd_take(rnd_take),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .busy(busy), .done(done)
    );

    always @(posedge clk) if (mem_rd_en) mem_fit <= fit_mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n)        rptr <= 0;
        else if (rnd_take) rptr <= rptr + 1;
    end
    assign rnd_in = rseq[rptr];

    always @(negedge clk) begin
        if (pick_valid && ngot < 64) begin got[ngot] = pick_idx; ngot++; end
        if (mem_rd_en && !seen_take && nrd < 64) begin rdlog[nrd] = mem_addr; nrd++; end
        if (rnd_take) seen_take = 1'b1;
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int expd);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expd);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_total++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    // Expected picks computed from the requirement formulas
    task automatic build_expect(int base, int n, int k);
        int p = base;
        int tot = 0;
        for (int i = 0; i < n; i++) tot += fit_mem[i];
        for (int pk = 0; pk < n; pk++) begin
            int ci [2];
            int cf [2];
            int r;
            bit aw;
            for (int c = 0; c < 2; c++) begin
                int w = rseq[p];
                p++;
                if (tot == 0) begin
                    ci[c] = (w * n) >> 16; cf[c] = 0;
                end else begin
                    int tg = (w * tot) >> 16;
                    int s = 0;
                    bit hit = 1'b0;
                    ci[c] = n - 1; cf[c] = 0;
                    for (int i = 0; i < n; i++) begin
                        s += fit_mem[i];
                        if (!hit && s > tg) begin ci[c] = i; cf[c] = fit_mem[i]; hit = 1'b1; end
                    end
                end
            end
            r = rseq[p] & 255;
            p++;
            if (r < k) aw = (cf[0] >= cf[1]);
            else       aw = (cf[0] <= cf[1]);
            expv[pk] = aw ? ci[0] : ci[1];
        end
        exp_end = p;
    endtask

    task automatic run_round(int n, int k, bit disturb, string req);
        int base;
        int cyc = 0;
        @(posedge clk); #2;
        base = rptr; ngot = 0; nrd = 0; seen_take = 1'b0;
        start = 1'b1; pop_count = 5'(n); thresh_k = 8'(k);
        @(posedge clk); #2;
        start = 1'b0;
        if (disturb) begin
            repeat (10) @(posedge clk);
            #2;
            start = 1'b1; pop_count = 5'd3; thresh_k = 8'(255 - k);
            @(posedge clk); #2;
            start = 1'b0;
        end
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        chk(done == 1'b1, "R8", "round finished", done, 1);
        build_expect(base, n, k);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ngot == n, "R8", "pick count", ngot, n);
        for (int i = 0; i < n && i < ngot; i++)
            chk(got[i] == expv[i], req, $sformatf("pick %0d", i), got[i], expv[i]);
        chk(rptr == exp_end, "R4", "random words consumed", rptr - base, exp_end - base);
        if (n > 0 && fit_mem_total(n) != 0) begin
            chk(nrd == n, "R2", "reads before first random word", nrd, n);
            for (int i = 0; i < n && i < nrd; i++)
                chk(rdlog[i] == i, "R2", "total pass address", rdlog[i], i);
        end
        chk(done == 1'b1 && busy == 1'b0, "R8", "done held while idle", {done, busy}, 2);
    endtask

    function automatic int fit_mem_total(int n);
        int t = 0;
        for (int i = 0; i < n; i++) t += fit_mem[i];
        return t;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(pick_valid == 0 && done == 0 && busy == 0 && mem_rd_en == 0 && rnd_take == 0,
            "R1", "outputs after reset",
            {pick_valid, done, busy, mem_rd_en, rnd_take}, 0);
    endtask

    task automatic t_hand_roulette();
        // R3: fitness 0,10,0,30; w=0x8000 -> t=20 -> idx3; w=0 -> t=0 -> idx1; r=0<k=1 -> fitter idx3
        fit_mem[0] = 8'd0; fit_mem[1] = 8'd10; fit_mem[2] = 8'd0; fit_mem[3] = 8'd30;
        rseq[rptr] = 16'h8000; rseq[rptr+1] = 16'h0000; rseq[rptr+2] = 16'h0000;
        run_round(4, 1, 1'b0, "R3");
        chk(got[0] == 3, "R3", "hand roulette pick", got[0], 3);
    endtask

    task automatic t_hand_tie();
        // R6: fitness 5,5; spins pick 0 then 1; k=0 selects weaker, tie -> first (0)
        fit_mem[0] = 8'd5; fit_mem[1] = 8'd5;
        rseq[rptr] = 16'h0000; rseq[rptr+1] = 16'hC000; rseq[rptr+2] = 16'h0000;
        run_round(2, 0, 1'b0, "R6");
        chk(got[0] == 0, "R6", "tie goes to first draw", got[0], 0);
    endtask

    task automatic fill_mixed();
        for (int i = 0; i < 16; i++) fit_mem[i] = 8'((i * 37 + 11) % 256);
        fit_mem[0] = 8'd0; fit_mem[5] = 8'd0; fit_mem[9] = 8'd3;
    endtask

    task automatic t_mixed();
        fill_mixed();
        run_round(16, 200, 1'b0, "R3");
    endtask

    task automatic t_k_zero();
        fill_mixed();
        run_round(8, 0, 1'b0, "R5");
    endtask

    task automatic t_k_max();
        fill_mixed();
        run_round(12, 255, 1'b0, "R5");
    endtask

    task automatic t_all_equal();
        for (int i = 0; i < 16; i++) fit_mem[i] = 8'd20;
        run_round(10, 128, 1'b0, "R6");
    endtask

    task automatic t_zero_total();
        for (int i = 0; i < 16; i++) fit_mem[i] = 8'd0;
        run_round(7, 100, 1'b0, "R7");
        chk(nrd == 7, "R7", "only the total pass reads memory", nrd, 7);
    endtask

    task automatic t_busy_start();
        fill_mixed();
        run_round(9, 90, 1'b1, "R9");
    endtask

    task automatic t_empty();
        int base;
        @(posedge clk); #2;
        base = rptr; ngot = 0; nrd = 0;
        start = 1'b1; pop_count = 5'd0;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R10", "done for empty round", done, 1);
        chk(ngot == 0, "R10", "no picks", ngot, 0);
        chk(nrd == 0, "R10", "no reads", nrd, 0);
        chk(rptr == base, "R10", "no random words", rptr - base, 0);
    endtask

    initial begin
        int seed = 32'h1357;
        for (int i = 0; i < 1024; i++) begin
            seed = seed * 1103515245 + 12345;
            rseq[i] = 16'(seed >>> 11);
        end
        for (int i = 0; i < 16; i++) fit_mem[i] = '0;
        ngot = 0; nrd = 0; seen_take = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_hand_roulette();
        t_hand_tie();
        t_mixed();
        t_k_zero();
        t_k_max();
        t_all_equal();
        t_zero_total();
        t_busy_start();
        t_empty();
        summary();
        $finish;
    end
endmodule